// File: doc/BRIEF.md
# Leaf Page Entry Permission Checker

This block judges a single leaf entry of a radix translation tree against one memory access. It decodes the entry's access-authority nibble into a read/write/execute permission set, then narrows that set according to the privilege of the page and of the requester. For a supervisor access to an ordinary (non-privileged) page, the set is also intersected with the key-0 fields of the data access-mask and instruction access-mask registers. The checker then compares the narrowed set with the permission that the access type needs and raises a fault with a cause code when the access may not proceed.

Before any of that, it looks at the storage attribute field of the entry. An instruction fetch from a guarded page faults at once with its own cause code. All results are registered, so a request presented with `in_valid` appears on the outputs one clock later, flagged by `out_valid`.

Top module: `pte_perm_check`

## Requirements
- R1: While reset is active and in the cycle after it, `out_valid`, `perm`, `fault` and `cause` are all zero.
- R2: A request sampled with `in_valid` high at a rising edge drives its result and `out_valid`=1 after that same edge. `out_valid` is 0 after an edge where `in_valid` was low, and `perm`, `fault` and `cause` then keep their previous values.
- R3: If entry bits 5:4 equal 2'b10 (guarded) and `acc_type` is 2 (fetch), then `fault`=1, `cause`=32'h1000_0000 and `perm`=3'b000, regardless of every other input.
- R4: The access-authority bits are entry bits 3:0. Bit 2 grants read, bit 1 grants read and write, and bit 0 grants execute. `perm` is encoded as bit 0 = read, bit 1 = write, bit 2 = execute.
- R5: If entry bit 3 (privileged page) is 1 and `user` is 1, `perm` is 3'b000.
- R6: A user access (`user`=1) to a page with bit 3 = 0, or a supervisor access (`user`=0) to a page with bit 3 = 1, reports the decoded authority of R4 unchanged, whatever the values of `amask` and `imask`.
- R7: A supervisor access to a page with bit 3 = 0 reports the decoded authority ANDed with the masks. `amask[1]`=1 removes write, `amask[0]`=1 removes read, and `imask[0]`=1 removes execute. `imask[1]` has no effect.
- R8: `acc_type` 0 needs read, 1 needs write and 2 needs execute. If the needed permission is missing from `perm`, then `fault`=1 and `cause`=32'h0800_0000, and `perm` still reports the granted set.
- R9: `acc_type` 3 always produces a protection fault with `cause`=32'h0800_0000, unless R3 applies. R3 cannot apply here, because R3 needs `acc_type` 2.
- R10: Without a fault, `cause` is 0. The attribute encodings 2'b00, 2'b01 and 2'b11, and the guarded encoding with a read or write access, change neither `perm` nor `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| pte | input | 64 | Leaf page-table entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| user | input | 1 | Problem-state (user) access |
| amask | input | 2 | Key-0 field of the data access mask |
| imask | input | 2 | Key-0 field of the instruction access mask |
| out_valid | output | 1 | Result valid this cycle |
| perm | output | 3 | Granted permissions {exec, write, read} |
| fault | output | 1 | Access denied |
| cause | output | 32 | Fault cause code, 0 when no fault |

## Verification
The assertions take for granted that every input carries a known value whenever `in_valid` is high, and that inputs are sampled only on those cycles. They make no assumption about `acc_type`; its reserved value 3 is a legal stimulus. The bench changes all inputs only on falling edges. It draws entries, access types, privilege and mask fields from a fixed-seed generator, so every combination of the attribute and authority fields occurs, including the reserved access type. Idle cycles between requests exercise the hold behaviour.

// File: rtl/pte_perm_check.sv
module pte_perm_check #(
  parameter int PTE_W   = 64,
  parameter int CAUSE_W = 32,
  parameter logic [CAUSE_W-1:0] GUARD_CAUSE = 32'h1000_0000,
  parameter logic [CAUSE_W-1:0] PROT_CAUSE  = 32'h0800_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PTE_W-1:0]   pte,
  input  logic [1:0]         acc_type,
  input  logic               user,
  input  logic [1:0]         amask,
  input  logic [1:0]         imask,
  output logic               out_valid,
  output logic [2:0]         perm,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  localparam int ATT_LO = 4;
  localparam logic [1:0] ATT_GUARDED = 2'b10;

  logic [3:0] auth;
  logic [2:0] dec, keep, grant, need;
  logic       guard_hit, denied;
  logic       unused_bits;

  assign auth  = pte[3:0];
  assign dec   = {auth[0], auth[1], auth[2] | auth[1]};
  assign keep  = {~imask[0], ~amask[1], ~amask[0]};
  assign grant = (user && auth[3]) ? 3'b000 :
                 (user || auth[3]) ? dec : (dec & keep);
  assign guard_hit = (pte[ATT_LO+1:ATT_LO] == ATT_GUARDED) && (acc_type == 2'd2);
  assign unused_bits = ^{pte[PTE_W-1:ATT_LO+2], imask[1]};

  always_comb begin
    case (acc_type)
      2'd0:    need = 3'b001;
      2'd1:    need = 3'b010;
      2'd2:    need = 3'b100;
      default: need = 3'b000;
    endcase
  end

  assign denied = (acc_type == 2'd3) || ((grant & need) == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      perm      <= '0;
      fault     <= 1'b0;
      cause     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (guard_hit) begin
          perm  <= 3'b000;
          fault <= 1'b1;
          cause <= GUARD_CAUSE;
        end else begin
          perm  <= grant;
          fault <= denied;
          cause <= denied ? PROT_CAUSE : '0;
        end
      end
    end
  end
endmodule

module pte_perm_check_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] pte,
  input logic [1:0]  acc_type,
  input logic        user,
  input logic        out_valid,
  input logic [2:0]  perm,
  input logic        fault,
  input logic [31:0] cause
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(perm) && $stable(cause)));
  // R3
  guard_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_type == 2'd2 && pte[5:4] == 2'b10) |=>
      (fault && cause == 32'h1000_0000 && perm == 3'b000));
  // R5
  user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && user && pte[3]) |=> (perm == 3'b000));
  // R9
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_type == 2'd3) |=> (fault && cause == 32'h0800_0000));
  // R10
  cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (cause == 32'h0));
  // R8
  single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($countones(cause) == 1));
endmodule

bind pte_perm_check pte_perm_check_chk u_chk (.*);

// File: tb/tb_pte_perm_check.sv
`timescale 1ns/1ps
module tb_pte_perm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc_type = '0;
  logic        user = 1'b0;
  logic [1:0]  amask = '0;
  logic [1:0]  imask = '0;
  logic        out_valid;
  logic [2:0]  perm;
  logic        fault;
  logic [31:0] cause;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pte_perm_check dut (.*);

  function automatic logic [35:0] model(logic [63:0] p, logic [1:0] a,
                                        logic u, logic [1:0] am, logic [1:0] im);
    logic [2:0] d, g, n;
    logic f;
    if (p[5:4] == 2'b10 && a == 2'd2) return {1'b1, 3'b000, 32'h1000_0000};
    d = {p[0], p[1], p[2] | p[1]};
    if (u && p[3]) g = 3'b000;
    else if (u || p[3]) g = d;
    else g = {d[2] & ~im[0], d[1] & ~am[1], d[0] & ~am[0]};
    n = (a == 2'd0) ? 3'b001 : (a == 2'd1) ? 3'b010 : (a == 2'd2) ? 3'b100 : 3'b000;
    f = (a == 2'd3) || ((g & n) == 3'b000);
    return {f, g, f ? 32'h0800_0000 : 32'h0};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got fault=%0b perm=%03b cause=%08h, expected fault=%0b perm=%03b cause=%08h",
               tag, act[35], act[34:32], act[31:0], exp[35], exp[34:32], exp[31:0]);
    end
  endtask

  task automatic apply(string tag, logic [63:0] p, logic [1:0] a, logic u,
                       logic [1:0] am, logic [1:0] im);
    @(negedge clk);
    pte = p; acc_type = a; user = u; amask = am; imask = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R2: out_valid=%0b expected 1", out_valid);
    end
    chk(tag, {fault, perm, cause}, model(p, a, u, am, im));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [35:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {fault, perm, cause}, 36'h0);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1: out_valid=%0b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {fault, perm, cause}, 36'h0);

    // R3 guarded fetch, even with full authority
    apply("R3", 64'h0000_0000_0000_0027, 2'd2, 1'b0, 2'b00, 2'b00);
    apply("R3", 64'hFFFF_FFFF_FFFF_FFE7, 2'd2, 1'b1, 2'b11, 2'b11);
    // R10 guarded with read/write does not fault
    apply("R10", 64'h0000_0000_0000_0022, 2'd1, 1'b0, 2'b00, 2'b00);
    apply("R10", 64'h0000_0000_0000_0034, 2'd0, 1'b1, 2'b00, 2'b00);
    apply("R10", 64'h0000_0000_0000_0011, 2'd2, 1'b1, 2'b00, 2'b00);
    // R4 decode
    apply("R4", 64'h4, 2'd1, 1'b1, 2'b00, 2'b00);
    apply("R4", 64'h2, 2'd0, 1'b1, 2'b00, 2'b00);
    apply("R4", 64'h1, 2'd2, 1'b1, 2'b00, 2'b00);
    // R5 user on privileged page
    apply("R5", 64'hF, 2'd0, 1'b1, 2'b00, 2'b00);
    // R6 masks ignored
    apply("R6", 64'h7, 2'd1, 1'b1, 2'b11, 2'b11);
    apply("R6", 64'hF, 2'd2, 1'b0, 2'b11, 2'b11);
    // R7 masks on supervisor to ordinary page
    apply("R7", 64'h7, 2'd1, 1'b0, 2'b10, 2'b00);
    apply("R7", 64'h5, 2'd0, 1'b0, 2'b01, 2'b00);
    apply("R7", 64'h1, 2'd2, 1'b0, 2'b00, 2'b01);
    apply("R7", 64'h1, 2'd2, 1'b0, 2'b00, 2'b10);
    // R8 missing permission
    apply("R8", 64'h4, 2'd1, 1'b0, 2'b00, 2'b00);
    // R9 reserved type
    apply("R9", 64'h7, 2'd3, 1'b0, 2'b00, 2'b00);

    // R2 hold while idle
    held = {fault, perm, cause};
    pte = 64'h0; acc_type = 2'd3;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R2: out_valid=%0b expected 0", out_valid); end
    chk("R2", {fault, perm, cause}, held);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      apply("R8", p, 2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
      if (($urandom % 4) == 0) @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule